// File: doc/BRIEF.md
# Valid-Strobe to AXI4-Stream Bridge with Skid Entry

This block joins a producer that speaks a reduced streaming convention (a data word plus a single-cycle valid strobe, throttled by a ready output) to an AXI4-Stream master port with tdata, tvalid and tready. The producer watches the ready output with one cycle of lag. It may therefore issue one more sample in the cycle after ready falls. A single skid register catches that late sample, so nothing is dropped when the downstream side stalls. The upstream ready is simply downstream tready, gated off while the skid entry is occupied.

A second path does the reverse. An AXI4-Stream slave port (s_tvalid, s_tdata, s_tready) feeds a reduced-convention consumer. The consumer throttles through out_ready and tolerates one beat after it drops that signal. This path drives s_tready from a one-cycle-delayed copy of out_ready, so at most one beat reaches the consumer after it stalls.

Back-pressure rules on the producer side:
- A sample counts as accepted when in_valid is high in a cycle where in_ready is high now, or was high in the previous cycle.
- Any other sample is discarded.
- The producer resumes only after in_ready returns high.
- On the master port, a beat moves only when tvalid and tready are both high.

Top module: `stream_skid_bridge`

## Requirements
- R1: While rst_n is low at a clock edge (synchronous, active low), the skid entry empties and the remembered ready history clears. The first cycle after release shows m_tvalid=0, s_tready=0 and out_valid=0, and in_ready equal to m_tready.
- R2: in_ready equals m_tready whenever the skid entry is empty, and is 0 in every cycle where the skid entry holds a sample.
- R3: A sample with in_valid=1 in a cycle where in_ready=1 appears in that same cycle on m_tdata with m_tvalid=1.
- R4: A sample with in_valid=1 in the cycle right after in_ready fell (in_ready=0 now, 1 one cycle earlier) is accepted and later delivered on the master port, even if m_tready stays low.
- R5: A sample with in_valid=1 in a cycle where in_ready is 0 and was also 0 one cycle earlier is ignored. It never appears on m_tdata and does not raise m_tvalid.
- R6: While m_tvalid=1 and m_tready=0, the next cycle keeps m_tvalid=1 and the same m_tdata.
- R7: Every accepted sample leaves the master port exactly once, in acceptance order, with no extra beats.
- R8: s_tready equals the value out_ready had one cycle earlier.
- R9: out_valid is 1 exactly when s_tvalid and s_tready are both 1, and out_data then equals s_tdata.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Producer sample strobe |
| in_data | input | DATA_W | Producer sample |
| in_ready | output | 1 | Throttle toward producer |
| m_tvalid | output | 1 | Master beat valid |
| m_tdata | output | DATA_W | Master beat data |
| m_tready | input | 1 | Downstream readiness |
| s_tvalid | input | 1 | Slave beat valid |
| s_tdata | input | DATA_W | Slave beat data |
| s_tready | output | 1 | Readiness toward upstream source |
| out_valid | output | 1 | Consumer sample strobe |
| out_data | output | DATA_W | Consumer sample |
| out_ready | input | 1 | Consumer throttle |

## Verification
The hardest case to reach is a late sample landing in the cycle right after in_ready falls while m_tready stays low for several more cycles. The skid entry must then hold steady until tready returns, and it must not let a pass-through beat overtake it. Random traffic rarely lines these conditions up. The stimulus therefore sweeps every combination of in_valid and m_tready over six consecutive cycles, which places every stall-and-resume ordering right after a fall of in_ready. The slave path runs alongside on a pseudo-random pattern, checked against a one-cycle-delayed model of out_ready.

// File: rtl/stream_skid_pkg.sv
package stream_skid_pkg;
  typedef enum logic {
    SKID_EMPTY = 1'b0,
    SKID_HELD  = 1'b1
  } skid_state_e;
endpackage

// File: rtl/ssb_accept_window.sv
// Decides whether a producer sample counts: ready now, or ready one cycle ago.
module ssb_accept_window (
  input  logic clk,
  input  logic rst_n,
  input  logic ready_now,
  input  logic valid_in,
  output logic ready_prev,
  output logic accept
);
  always_ff @(posedge clk) begin
    if (!rst_n) ready_prev <= 1'b0;
    else        ready_prev <= ready_now;
  end

  assign accept = valid_in && (ready_now || ready_prev);
endmodule

// File: rtl/ssb_skid_stage.sv
module ssb_skid_stage
  import stream_skid_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [DATA_W-1:0] in_data,
  input  logic              m_tready,
  output logic              in_ready,
  output logic              m_tvalid,
  output logic [DATA_W-1:0] m_tdata
);
  skid_state_e       state_q;
  logic [DATA_W-1:0] hold_q;
  logic              held;

  assign held     = (state_q == SKID_HELD);
  assign in_ready = m_tready && !held;
  assign m_tvalid = held || accept;
  assign m_tdata  = held ? hold_q : in_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= SKID_EMPTY;
      hold_q  <= '0;
    end else if (held) begin
      if (m_tready) state_q <= SKID_EMPTY;
    end else if (accept && !m_tready) begin
      state_q <= SKID_HELD;
      hold_q  <= in_data;
    end
  end

  // R6: a stalled beat keeps its valid and its data
  assert_beat_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (m_tvalid && !m_tready) |=> (m_tvalid && $stable(m_tdata)));

  // R2: producer sees no ready while the skid entry is occupied
  assert_ready_blocked_R2: assert property (@(posedge clk) disable iff (!rst_n)
    held |-> !in_ready);

  // R4: the window never admits a second late sample on top of a held one
  assert_no_overrun_R4: assert property (@(posedge clk) disable iff (!rst_n)
    held |-> !accept);
endmodule

// File: rtl/ssb_slave_mirror.sv
module ssb_slave_mirror #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_tvalid,
  input  logic [DATA_W-1:0] s_tdata,
  output logic              s_tready,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  input  logic              out_ready
);
  logic ready_d;

  always_ff @(posedge clk) begin
    if (!rst_n) ready_d <= 1'b0;
    else        ready_d <= out_ready;
  end

  assign s_tready  = ready_d;
  assign out_valid = s_tvalid && ready_d;
  assign out_data  = s_tdata;

  // R8: readiness toward the source trails the consumer by one cycle
  assert_ready_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && out_ready) |=> s_tready);
  assert_ready_drops_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && !out_ready) |=> !s_tready);

  // R9: no beat reaches the consumer unless it was ready one cycle ago
  assert_no_late_beat_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(out_ready));
endmodule

// File: rtl/stream_skid_bridge.sv
module stream_skid_bridge #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  output logic              m_tvalid,
  output logic [DATA_W-1:0] m_tdata,
  input  logic              m_tready,
  input  logic              s_tvalid,
  input  logic [DATA_W-1:0] s_tdata,
  output logic              s_tready,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  input  logic              out_ready
);
  logic accept;
  logic ready_prev;

  ssb_accept_window u_window (
    .clk        (clk),
    .rst_n      (rst_n),
    .ready_now  (in_ready),
    .valid_in   (in_valid),
    .ready_prev (ready_prev),
    .accept     (accept)
  );

  ssb_skid_stage #(.DATA_W(DATA_W)) u_skid (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept   (accept),
    .in_data  (in_data),
    .m_tready (m_tready),
    .in_ready (in_ready),
    .m_tvalid (m_tvalid),
    .m_tdata  (m_tdata)
  );

  ssb_slave_mirror #(.DATA_W(DATA_W)) u_mirror (
    .clk       (clk),
    .rst_n     (rst_n),
    .s_tvalid  (s_tvalid),
    .s_tdata   (s_tdata),
    .s_tready  (s_tready),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_ready (out_ready)
  );

  // R5: with ready low now and one cycle ago, a strobe raises no beat by itself
  assert_stale_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_ready && !ready_prev && !m_tvalid) |-> !accept);
endmodule

// File: tb/stream_skid_bridge_test.sv
`timescale 1ns/1ps
module stream_skid_bridge_test;
  localparam int W = 8;
  localparam int STEPS = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, m_tready = 1'b1, s_tvalid = 1'b0, out_ready = 1'b0;
  logic [W-1:0] in_data = '0, s_tdata = '0;
  logic in_ready, m_tvalid, s_tready, out_valid;
  logic [W-1:0] m_tdata, out_data;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  stream_skid_bridge #(.DATA_W(W)) uut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .m_tvalid(m_tvalid), .m_tdata(m_tdata), .m_tready(m_tready),
    .s_tvalid(s_tvalid), .s_tdata(s_tdata), .s_tready(s_tready),
    .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready)
  );

  // requirement model state
  bit         mdl_full = 0;
  bit [W-1:0] mdl_data = '0;
  bit         mdl_rprev = 0;
  bit         mdl_oprev = 0;
  bit         prev_tv = 0, prev_tr = 1;
  bit [W-1:0] prev_td = '0;
  bit [W-1:0] fifo [16];
  int         wr = 0, rd = 0;
  int         late_hits = 0;
  bit [W-1:0] seq = '0;
  bit [15:0]  lfsr = 16'hACE1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cycle(input bit iv, input bit tr);
    bit exp_ir, acc, exp_tv, exp_st, exp_ov, so, oo;
    bit [W-1:0] exp_td, sd;
    @(negedge clk);
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    so = lfsr[0]; oo = lfsr[3] | lfsr[5]; sd = lfsr[W+1:2];
    seq = seq + 1'b1;
    in_valid = iv; in_data = seq; m_tready = tr;
    s_tvalid = so; s_tdata = sd; out_ready = oo;
    #1;
    exp_ir = tr && !mdl_full;
    acc    = iv && (exp_ir || mdl_rprev);
    exp_tv = mdl_full || acc;
    exp_td = mdl_full ? mdl_data : seq;
    chk(in_ready == exp_ir, "R2 in_ready", in_ready, exp_ir);
    if (iv && !exp_ir && !mdl_rprev)
      chk(m_tvalid == mdl_full, "R5 stale sample ignored", m_tvalid, mdl_full);
    else
      chk(m_tvalid == exp_tv, "R3 m_tvalid", m_tvalid, exp_tv);
    if (exp_tv) chk(m_tdata == exp_td, "R3 m_tdata", m_tdata, exp_td);
    if (prev_tv && !prev_tr) begin
      chk(m_tvalid == 1'b1, "R6 valid held", m_tvalid, 1);
      chk(m_tdata == prev_td, "R6 data held", m_tdata, prev_td);
    end
    if (acc) begin
      fifo[wr % 16] = seq; wr++;
      if (!exp_ir) late_hits++;
    end
    if (m_tvalid && tr) begin
      chk(rd < wr, "R7 no extra beat", rd, wr);
      if (rd < wr) begin
        chk(m_tdata == fifo[rd % 16], "R7 order", m_tdata, fifo[rd % 16]);
        rd++;
      end
    end
    exp_st = mdl_oprev;
    exp_ov = so && exp_st;
    chk(s_tready == exp_st, "R8 s_tready", s_tready, exp_st);
    chk(out_valid == exp_ov, "R9 out_valid", out_valid, exp_ov);
    if (exp_ov) chk(out_data == sd, "R9 out_data", out_data, sd);
    prev_tv = m_tvalid; prev_tr = tr; prev_td = m_tdata;
    mdl_rprev = exp_ir;
    mdl_oprev = oo;
    if (mdl_full && tr) mdl_full = 0;
    else if (acc && !tr && !mdl_full) begin mdl_full = 1; mdl_data = seq; end
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: state after reset
    chk(m_tvalid == 1'b0, "R1 m_tvalid after reset", m_tvalid, 0);
    chk(s_tready == 1'b0, "R1 s_tready after reset", s_tready, 0);
    chk(out_valid == 1'b0, "R1 out_valid after reset", out_valid, 0);
    chk(in_ready == m_tready, "R1 in_ready after reset", in_ready, m_tready);
    mdl_rprev = 0; mdl_oprev = 0; mdl_full = 0;
    for (int p = 0; p < (1 << (2 * STEPS)); p++) begin
      for (int s = 0; s < STEPS; s++)
        cycle(p[2*s], p[2*s+1]);
      cycle(1'b0, 1'b1);
      cycle(1'b0, 1'b1);
    end
    repeat (3) cycle(1'b0, 1'b1);
    // R7: everything accepted has left; R4: late samples were exercised
    chk(rd == wr, "R7 all delivered", rd, wr);
    chk(late_hits > 0, "R4 late sample seen", late_hits, 1);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule